// File: doc/BRIEF.md
# Quadrature Position Counter

This block keeps a signed-free 16-bit position count for an incremental rotary or linear encoder. Phase A and phase B come straight from the sensor. The block works out the count enable and the count direction from those two phases on its own, so the register value always follows the mechanical position. There are no separate count and direction pins. A third sensor line, the index or zero marker, does not touch the count. Its rising edge raises a one-cycle interrupt request.

A 2-bit field selects which edges are counted: edges of phase A only, edges of phase B only, or edges of both phases (four counts per encoder cycle). Every input passes through a two-flop synchronizer before edge detection. A change seen on both phases in the same sample is not a valid quadrature step. Such a change is discarded and sets a sticky error flag. When the count rolls over in either direction, the block emits a one-cycle wrap interrupt.

Top module: `quad_pos_counter`

## Requirements
- R1: After reset, position is 0, dirDown is 0, and illegalErr, idxIrq and wrapIrq are all 0.
- R2: With edgeSel = 2'b10 or 2'b11, every single-phase change counts. When A leads B (the (A,B) order 00,10,11,01,00), each step adds 1.
- R3: With edgeSel = 2'b10 or 2'b11, the reverse order 00,01,11,10,00 subtracts 1 for each step.
- R4: With edgeSel = 2'b00, only changes of A count. A change of B alone leaves position unchanged.
- R5: With edgeSel = 2'b01, only changes of B count. A change of A alone leaves position unchanged.
- R6: A sample in which A and B both differ from the previous sample changes neither position nor dirDown. It sets illegalErr, which then stays 1 until reset.
- R7: dirDown is 1 after the most recent counted step was a decrement and 0 after it was an increment. Steps that are not counted leave it unchanged.
- R8: A step from 0xFFFF up to 0, or from 0 down to 0xFFFF, gives exactly one cycle of wrapIrq. Other steps give none.
- R9: A rising edge on encIdx gives exactly one cycle of idxIrq and leaves position unchanged.
- R10: A phase change applied just before a clock edge appears on position after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| encA | input | 1 | Encoder phase A (asynchronous) |
| encB | input | 1 | Encoder phase B (asynchronous) |
| encIdx | input | 1 | Encoder index marker (asynchronous) |
| edgeSel | input | 2 | 00: A edges, 01: B edges, 1x: both phases |
| position | output | 16 | Current position count |
| dirDown | output | 1 | Direction of last counted step, 1 = down |
| illegalErr | output | 1 | Sticky flag for a simultaneous A/B change |
| idxIrq | output | 1 | One-cycle pulse on index rising edge |
| wrapIrq | output | 1 | One-cycle pulse on overflow or underflow |

## Verification
The hardest case to reach is the rollover boundary. Walking up to 0xFFFF would take tens of thousands of encoder steps. The stimulus therefore steps backward from zero to cause an underflow, then forward again to cause an overflow, and counts wrap pulses on every cycle. The illegal double change is the other awkward case, because the two phases must move within one sample. The bench drives both phases on the same falling clock edge so that both changes land in one synchronizer sample. The bench then recomputes its quadrature phase so that normal stepping can resume.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  // Strobes from the decoder to the datapath, valid for one cycle
  typedef struct packed {
    logic up;
    logic dn;
    logic illegal;
    logic idxEdge;
  } qpc_strobe_t;
endpackage

// File: rtl/qpc_ctrl.sv
module qpc_ctrl
  import qpc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        encA,
  input  logic        encB,
  input  logic        encIdx,
  input  logic [1:0]  edgeSel,
  output qpc_strobe_t strb
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] shA, shB, shI;
  logic prvA, prvB, prvI;
  logic curA, curB, curI;
  logic chgA, chgB, useA, useB;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shA  <= '0;
      shB  <= '0;
      shI  <= '0;
      prvA <= 1'b0;
      prvB <= 1'b0;
      prvI <= 1'b0;
    end else begin
      shA  <= {shA[TOP-1:0], encA};
      shB  <= {shB[TOP-1:0], encB};
      shI  <= {shI[TOP-1:0], encIdx};
      prvA <= shA[TOP];
      prvB <= shB[TOP];
      prvI <= shI[TOP];
    end
  end

  assign curA = shA[TOP];
  assign curB = shB[TOP];
  assign curI = shI[TOP];
  assign chgA = curA ^ prvA;
  assign chgB = curB ^ prvB;
  assign useA = (edgeSel != 2'b01);
  assign useB = (edgeSel != 2'b00);

  always_comb begin
    strb = '0;
    strb.idxEdge = curI & ~prvI;
    if (chgA && chgB) begin
      strb.illegal = 1'b1;
    end else if (chgA && useA) begin
      // A moved: up when A now differs from B (A leads)
      strb.up = (curA != curB);
      strb.dn = (curA == curB);
    end else if (chgB && useB) begin
      // B moved: up when B now equals A (B trails)
      strb.up = (curB == curA);
      strb.dn = (curB != curA);
    end
  end

  // R6: a double change never also produces a count strobe
  a_r6_no_count_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.up, strb.dn, strb.illegal}));
endmodule

// File: rtl/qpc_datapath.sv
module qpc_datapath
  import qpc_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  qpc_strobe_t      strb,
  output logic [WIDTH-1:0] count,
  output logic             dirDown,
  output logic             errFlag,
  output logic             idxIrq,
  output logic             wrapIrq
);
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ALL1 = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      dirDown <= 1'b0;
      errFlag <= 1'b0;
      idxIrq  <= 1'b0;
      wrapIrq <= 1'b0;
    end else begin
      idxIrq  <= strb.idxEdge;
      wrapIrq <= (strb.up && count == ALL1) || (strb.dn && count == ZERO);
      if (strb.illegal) errFlag <= 1'b1;
      if (strb.up) begin
        count   <= count + ONE;
        dirDown <= 1'b0;
      end else if (strb.dn) begin
        count   <= count - ONE;
        dirDown <= 1'b1;
      end
    end
  end

  // R2/R3: position moves by exactly one per cycle at most
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (count != $past(count)) |-> ((count - $past(count)) == ONE || ($past(count) - count) == ONE));
  // R6: error flag is sticky
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |=> errFlag);
  // R6: illegal sample leaves the count alone
  a_r6_hold_on_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    strb.illegal |=> $stable(count));
  // R8: a wrap pulse only accompanies a boundary value
  a_r8_wrap_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
    wrapIrq |-> (count == ZERO || count == ALL1));
  // R9: index pulse lasts one cycle
  a_r9_idx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    idxIrq |=> !idxIrq);
  // R7: direction bit agrees with the last step taken
  a_r7_dir_follows: assert property (@(posedge clk) disable iff (!rst_n)
    strb.dn |=> dirDown);
endmodule

// File: rtl/quad_pos_counter.sv
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             encA,
  input  logic             encB,
  input  logic             encIdx,
  input  logic [1:0]       edgeSel,
  output logic [WIDTH-1:0] position,
  output logic             dirDown,
  output logic             illegalErr,
  output logic             idxIrq,
  output logic             wrapIrq
);
  qpc_strobe_t strb;

  qpc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .encA    (encA),
    .encB    (encB),
    .encIdx  (encIdx),
    .edgeSel (edgeSel),
    .strb    (strb)
  );

  qpc_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .count   (position),
    .dirDown (dirDown),
    .errFlag (illegalErr),
    .idxIrq  (idxIrq),
    .wrapIrq (wrapIrq)
  );
endmodule

// File: tb/quad_pos_counter_tb_top.sv
module quad_pos_counter_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, encA, encB, encIdx;
  logic [1:0] edgeSel;
  logic [15:0] position;
  logic dirDown, illegalErr, idxIrq, wrapIrq;

  int total = 0, bad = 0, wrapSeen = 0, idxSeen = 0;
  bit done = 1'b0;
  logic [15:0] expPos = 16'd0;
  bit expDir = 1'b0, expErr = 1'b0, pa = 1'b0, pb = 1'b0;
  int ph = 0;

  quad_pos_counter dut_i (
    .clk(clk), .rst_n(rst_n), .encA(encA), .encB(encB), .encIdx(encIdx),
    .edgeSel(edgeSel), .position(position), .dirDown(dirDown),
    .illegalErr(illegalErr), .idxIrq(idxIrq), .wrapIrq(wrapIrq)
  );

  always @(negedge clk) if (rst_n) begin
    if (wrapIrq) wrapSeen++;
    if (idxIrq) idxSeen++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int phOf(bit a, bit b);
    return (!a && !b) ? 0 : (a && !b) ? 1 : (a && b) ? 2 : 3;
  endfunction

  task automatic step(bit a, bit b);
    bit up;
    @(negedge clk);
    encA = a; encB = b;
    if (a != pa && b != pb) expErr = 1'b1;
    else if (a != pa && edgeSel != 2'b01) begin
      up = (a != b); expPos += up ? 16'd1 : 16'hFFFF; expDir = !up;
    end else if (b != pb && edgeSel != 2'b00) begin
      up = (b == a); expPos += up ? 16'd1 : 16'hFFFF; expDir = !up;
    end
    pa = a; pb = b; ph = phOf(a, b);
    repeat (4) @(negedge clk);
  endtask

  task automatic fwd();
    int n = (ph + 1) % 4;
    step(n == 1 || n == 2, n == 2 || n == 3);
  endtask

  task automatic back();
    int n = (ph + 3) % 4;
    step(n == 1 || n == 2, n == 2 || n == 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w0;
    logic [15:0] hold;
    rst_n = 1'b0; encA = 1'b0; encB = 1'b0; encIdx = 1'b0; edgeSel = 2'b10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 position", position, 0);
    chk("R1 dirDown", dirDown, 0);
    chk("R1 illegalErr", illegalErr, 0);
    chk("R1 irqs", {idxIrq, wrapIrq}, 0);

    // R10 latency: change just after a falling edge
    @(negedge clk); encA = 1'b1;
    repeat (2) @(posedge clk); #1;
    chk("R10 after two edges", position, 0);
    @(posedge clk); #1;
    chk("R10 after three edges", position, 1);
    pa = 1'b1; expPos = 16'd1; ph = 1;
    repeat (3) @(negedge clk);

    // R2..R5, R7 sweeps over all edge selections
    for (int m = 0; m < 4; m++) begin
      edgeSel = 2'(m);
      for (int k = 0; k < 8; k++) begin
        fwd();
        chk(m == 0 ? "R4 fwd" : m == 1 ? "R5 fwd" : "R2 fwd", position, expPos);
        chk("R7 dir fwd", dirDown, expDir);
      end
      for (int k = 0; k < 8; k++) begin
        back();
        chk(m == 0 ? "R4 back" : m == 1 ? "R5 back" : "R3 back", position, expPos);
        chk("R7 dir back", dirDown, expDir);
      end
    end
    chk("R8 no wrap during sweeps", wrapSeen, 0);

    // R8 underflow then overflow
    edgeSel = 2'b10;
    for (int k = 0; k < 20 && expPos != 16'd0; k++) back();
    chk("R8 at zero", position, 0);
    w0 = wrapSeen;
    back();
    chk("R8 underflow value", position, 16'hFFFF);
    chk("R8 underflow pulse", wrapSeen, w0 + 1);
    fwd();
    chk("R8 overflow value", position, 0);
    chk("R8 overflow pulse", wrapSeen, w0 + 2);
    fwd();
    chk("R8 no extra pulse", wrapSeen, w0 + 2);

    // R9 index
    hold = position;
    @(negedge clk); encIdx = 1'b1;
    repeat (3) @(negedge clk); encIdx = 1'b0;
    repeat (5) @(negedge clk);
    chk("R9 index pulse count", idxSeen, 1);
    chk("R9 position untouched", position, hold);

    // R6 illegal double change
    hold = position;
    chk("R6 flag clear before", illegalErr, 0);
    step(!pa, !pb);
    chk("R6 flag set", illegalErr, 1);
    chk("R6 position held", position, hold);
    chk("R7 dir held", dirDown, expDir);
    fwd();
    chk("R6 count resumes", position, expPos);
    back(); back();
    chk("R6 count after illegal", position, expPos);
    chk("R6 flag sticky", illegalErr, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule